// File: doc/BRIEF.md
# Word-Sum Image Integrity Sequencer

This block checks, or repairs, a 16-bit additive checksum over the start of a non-volatile word image. It fetches words one at a time through a read request/response port, starting at word 0. It adds them into a 16-bit accumulator that drops any carry out of bit 15.

In check mode the block reads every word up to and including a fixed checksum slot. The image is good when the total equals a fixed signature, 0xBABA by default.

In repair mode the block reads only the words in front of the checksum slot. It then writes the signature minus that total into the slot through a single-word write port. After this, a later check of the same image passes.

A read fault stops either mode at once. A write fault is reported. The outcome stays on the status output until the next command is accepted.

Top module: `word_sum_guard`

## Requirements
- R1: The running total is a 16-bit sum that wraps on overflow. For example, sixty-three words of 0xFFFF total 0xFFC1.
- R2: In check mode (`mode`=0) the block reads words 0 through `CSUM_IDX` inclusive. It reports status 0 (good) when the 16-bit total equals `SIGNATURE`, and status 1 (mismatch) otherwise.
- R3: In repair mode (`mode`=1) the block reads words 0 through `CSUM_IDX`-1. It then holds `wr_req` with `wr_addr`=`CSUM_IDX` and `wr_data`=(`SIGNATURE` minus the total, 16 bits) until `wr_done`. It reports status 0 when the write completes without fault.
- R4: A response with `rd_valid`=1 and `rd_err`=1 ends the operation in that cycle, with status 2. No further read is issued and no write is issued.
- R5: A write acknowledgement with `wr_done`=1 and `wr_err`=1 ends repair mode with status 3.
- R6: Only one read is outstanding at a time. Addresses go 0, 1, 2, … in order. `rd_req` and `rd_addr` stay steady until the cycle in which `rd_valid` is seen. `rd_req` and `wr_req` are never high together.
- R7: `done` is a one-cycle pulse in the cycle after the final response is taken. `busy` is high from the cycle after an accepted `start` until `done`. `status` changes only together with `done`, and otherwise holds its value.
- R8: A `start` seen while `busy` is high is ignored. It has no effect on the result or on the read and write traffic.
- R9: After reset, `busy`, `done`, `rd_req` and `wr_req` are 0 and `status` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| mode | input | 1 | 0 = check, 1 = repair; sampled with start |
| rd_req | output | 1 | Read request, held until response |
| rd_addr | output | AW | Word index being read |
| rd_valid | input | 1 | Read response present |
| rd_data | input | DW | Read word |
| rd_err | input | 1 | Read response carries a fault |
| wr_req | output | 1 | Write request, held until acknowledged |
| wr_addr | output | AW | Write index (always the checksum slot) |
| wr_data | output | DW | New checksum word |
| wr_done | input | 1 | Write acknowledged |
| wr_err | input | 1 | Write acknowledgement carries a fault |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 good, 1 mismatch, 2 read fault, 3 write fault |

## Verification
The summing is exercised with several kinds of image:
- Random images, some with a correct checksum slot and some with a wrong one, separate a pass from a mismatch.
- An image of all 0xFFFF words shows whether the carry is dropped (R1).
- Repair followed by check shows whether the repair range stops one word short of the slot. It also shows that the written value makes the image whole.

The error cases are checked at the ports:
- Read faults injected at the first word, at a middle word and at the last word show that traffic stops immediately, counted in reads and writes.
- A write fault is told apart from a good repair by its status.
- A second `start` during a run must leave the result unchanged.

Response latency from the responder is random, which tests the request-hold rules.

// File: rtl/word_sum_guard.sv
module word_sum_guard #(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int CSUM_IDX = 63,
  parameter logic [DW-1:0] SIGNATURE = 16'hBABA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          mode,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_valid,
  input  logic [DW-1:0] rd_data,
  input  logic          rd_err,
  output logic          wr_req,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  input  logic          wr_done,
  input  logic          wr_err,
  output logic          busy,
  output logic          done,
  output logic [1:0]    status
);
  localparam logic [AW-1:0] IDX    = AW'(CSUM_IDX);
  localparam logic [AW-1:0] IDX_M1 = AW'(CSUM_IDX - 1);
  localparam logic [1:0] ST_GOOD = 2'd0, ST_MISM = 2'd1, ST_RDERR = 2'd2, ST_WRERR = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE} state_t;

  state_t        st;
  logic [AW-1:0] addr;
  logic [DW-1:0] sum;
  logic          upd;

  wire [DW-1:0] sum_nxt = sum + rd_data;
  wire          at_last = (addr == (upd ? IDX_M1 : IDX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      addr   <= '0;
      sum    <= '0;
      upd    <= 1'b0;
      done   <= 1'b0;
      status <= ST_GOOD;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st   <= S_READ;
          addr <= '0;
          sum  <= '0;
          upd  <= mode;
        end
        S_READ: if (rd_valid) begin
          if (rd_err) begin
            status <= ST_RDERR;
            done   <= 1'b1;
            st     <= S_IDLE;
          end else begin
            sum <= sum_nxt;
            if (!at_last) addr <= addr + 1'b1;
            else if (upd) st <= S_WRITE;
            else begin
              status <= (sum_nxt == SIGNATURE) ? ST_GOOD : ST_MISM;
              done   <= 1'b1;
              st     <= S_IDLE;
            end
          end
        end
        S_WRITE: if (wr_done) begin
          status <= wr_err ? ST_WRERR : ST_GOOD;
          done   <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign rd_req  = (st == S_READ);
  assign rd_addr = addr;
  assign wr_req  = (st == S_WRITE);
  assign wr_addr = IDX;
  assign wr_data = SIGNATURE - sum;
  assign busy    = (st != S_IDLE);
endmodule

// File: rtl/word_sum_guard_chk.sv
module word_sum_guard_chk #(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int CSUM_IDX = 63
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          rd_req,
  input logic [AW-1:0] rd_addr,
  input logic          rd_valid,
  input logic          wr_req,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          wr_done,
  input logic          busy,
  input logic          done,
  input logic [1:0]    status
);
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_valid |=> rd_req && $stable(rd_addr)); // R6
  AST_RD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && rd_valid ##1 rd_req |-> rd_addr == $past(rd_addr) + 1'b1); // R6
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && wr_req)); // R6
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !wr_done |=> wr_req && $stable(wr_data)); // R3
  AST_WR_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> wr_addr == AW'(CSUM_IDX)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(status) |-> done); // R7
  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start |=> busy); // R7
endmodule

bind word_sum_guard word_sum_guard_chk #(.AW(AW), .DW(DW), .CSUM_IDX(CSUM_IDX)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .rd_req(rd_req), .rd_addr(rd_addr),
  .rd_valid(rd_valid), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
  .wr_done(wr_done), .busy(busy), .done(done), .status(status)
);

// File: tb/word_sum_guard_tb.sv
module word_sum_guard_tb;
  localparam int CS = 63;
  localparam logic [15:0] SIG = 16'hBABA;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mode = 1'b0;
  logic rd_req, rd_valid = 1'b0, rd_err = 1'b0, wr_req, wr_done = 1'b0, wr_err = 1'b0;
  logic [7:0] rd_addr, wr_addr;
  logic [15:0] rd_data = '0, wr_data;
  logic busy, done;
  logic [1:0] status;

  word_sum_guard u_dut (.clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data), .rd_err(rd_err),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_done(wr_done), .wr_err(wr_err),
    .busy(busy), .done(done), .status(status));

  always #10 clk = ~clk;

  logic [15:0] mem [0:CS];
  int errs = 0, checks = 0;
  int err_at = -1;
  bit wr_fault = 0;
  int rd_cnt = 0, wr_cnt = 0, ord_bad = 0, next_addr = 0, rdly = 0, wdly = 0;

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  function automatic logic [15:0] sum_to(input int last);
    logic [15:0] s = '0;
    for (int i = 0; i <= last; i++) s = s + mem[i];
    return s;
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      rd_valid = 1'b0; rd_err = 1'b0; wr_done = 1'b0; wr_err = 1'b0;
      if (rd_req) begin
        if (rdly == 0) begin
          if (int'(rd_addr) != next_addr) ord_bad++;
          next_addr++;
          rd_valid = 1'b1;
          rd_data  = mem[rd_addr[5:0]];
          rd_err   = (int'(rd_addr) == err_at);
          rd_cnt++;
          rdly = $urandom_range(0, 2);
        end else rdly--;
      end
      if (wr_req) begin
        if (wdly == 0) begin
          wr_done = 1'b1;
          wr_err  = wr_fault;
          if (!wr_fault) mem[wr_addr[5:0]] = wr_data;
          wr_cnt++;
          wdly = $urandom_range(0, 3);
        end else wdly--;
      end
    end
  end

  task automatic run_op(input bit m, input bit restart, output logic [1:0] st);
    int n = 0;
    rd_cnt = 0; wr_cnt = 0; ord_bad = 0; next_addr = 0;
    @(negedge clk); mode = m; start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (restart) begin
      repeat (5) @(negedge clk);
      mode = ~m; start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    while (!done && n < 2000) begin @(negedge clk); n++; end
    if (!done) chk(0, "R7 done timeout", 0, 1);
    st = status;
  endtask

  task automatic fill_random();
    for (int i = 0; i <= CS; i++) mem[i] = 16'($urandom);
  endtask

  task automatic fix_sum();
    mem[CS] = SIG - sum_to(CS - 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [1:0] st;
    logic [15:0] ev;
    void'($urandom(32'h5EED));
    fill_random();
    repeat (3) @(negedge clk);
    chk(!busy && !done && !rd_req && !wr_req && status == 2'd0, "R9 reset",
        {busy, done, rd_req, wr_req, status}, 0);
    rst_n = 1'b1;

    fix_sum();
    run_op(0, 0, st);
    chk(st == 2'd0, "R2 good image", st, 0);
    chk(rd_cnt == CS + 1 && ord_bad == 0, "R6 read sequence", rd_cnt, CS + 1);
    chk(!busy, "R7 busy cleared", busy, 0);
    repeat (10) @(negedge clk);
    chk(status == 2'd0 && !done, "R7 status held", status, 0);

    mem[7] = mem[7] ^ 16'h0100;
    run_op(0, 0, st);
    chk(st == 2'd1, "R2 corrupted image", st, 1);

    for (int i = 0; i < CS; i++) mem[i] = 16'hFFFF;
    mem[CS] = 16'h0;
    run_op(1, 0, st);
    chk(st == 2'd0 && mem[CS] == 16'hBAF9, "R1 wrap repair", mem[CS], 16'hBAF9);
    chk(rd_cnt == CS && wr_cnt == 1, "R3 repair read count", rd_cnt, CS);
    run_op(0, 0, st);
    chk(st == 2'd0, "R3 repaired image checks", st, 0);

    fill_random(); fix_sum();
    err_at = 20;
    run_op(0, 0, st);
    chk(st == 2'd2 && rd_cnt == 21, "R4 read fault check mode", rd_cnt, 21);
    err_at = 0;
    ev = mem[CS];
    run_op(1, 0, st);
    chk(st == 2'd2 && rd_cnt == 1 && wr_cnt == 0, "R4 read fault repair", wr_cnt, 0);
    chk(mem[CS] == ev, "R4 slot untouched", mem[CS], ev);
    err_at = CS;
    run_op(0, 0, st);
    chk(st == 2'd2 && rd_cnt == CS + 1, "R4 fault on last word", st, 2);
    err_at = -1;

    wr_fault = 1;
    run_op(1, 0, st);
    chk(st == 2'd3 && wr_cnt == 1, "R5 write fault", st, 3);
    wr_fault = 0;

    fill_random();
    ev = SIG - sum_to(CS - 1);
    run_op(1, 1, st);
    chk(st == 2'd0 && mem[CS] == ev && wr_cnt == 1 && rd_cnt == CS, "R8 start while busy",
        mem[CS], ev);

    for (int it = 0; it < 24; it++) begin
      fill_random();
      if ($urandom_range(0, 1) == 1) begin
        ev = SIG - sum_to(CS - 1);
        run_op(1, 0, st);
        chk(st == 2'd0 && mem[CS] == ev, "R3 random repair", mem[CS], ev);
        run_op(0, 0, st);
        chk(st == 2'd0, "R2 random after repair", st, 0);
      end else begin
        if ($urandom_range(0, 1) == 1) fix_sum();
        ev = (sum_to(CS) == SIG) ? 16'd0 : 16'd1;
        run_op(0, 0, st);
        chk(st == ev[1:0] && ord_bad == 0, "R2 random check", st, ev);
      end
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule